// File: doc/BRIEF.md
# Transactional Write Cache with Single-Cycle Commit and Abort

This block is a small fully associative cache that sits beside a core's regular data cache and holds every tentative write made inside a hardware transaction. Each line stores an address, one data word (an 8-byte line by default), a coherence state and a transaction tag. A transactional access keeps two copies of a line. One holds the value to restore if the transaction fails. The other holds the value being built up, and commits if the transaction succeeds. Both commit and abort therefore finish by retagging every line at once, in one cycle.

The core issues six operations on one request port: the three transactional accesses (plain load, load with intent to write, store) and the three control operations (validate, commit, abort). The block keeps the two transaction status bits, `tactive` and `tstatus`. It chooses eviction victims and writes back dirty victims. It fetches missing lines over an abstract bus port that uses a request/grant handshake and replies OK or BUSY. The default size is 64 lines. The number of lines, the address width and the data width are parameters (at least 2 lines).

Top module: `txcache`

## Requirements
- R1: After reset every line is EMPTY, `tactive` is 0, `tstatus` is 1, `req_ready` is 1, and `bus_req`, `resp_valid` and `tx_trap` are 0.
- R2: A transactional access (op 0 plain load, 1 load-exclusive, 2 store) accepted while `tactive` is 0 sets `tactive` to 1.
- R3: A transactional access that finds no copy of its address fetches the line with `bus_kind` 0 (shared read) for op 0, or 1 (exclusive read) for ops 1 and 2. On an OK reply it fills two free lines: an old copy tagged XCOMMIT, and a new copy tagged XABORT that holds the store data for op 2. Loads return the fetched data, and every successful access returns `resp_flag` 1.
- R4: A transactional access that finds the address tagged XABORT uses that copy without any bus cycle. Loads return its data, and a store overwrites it.
- R5: An access that finds the address tagged NORMAL retags that line XCOMMIT and makes an XABORT copy in a free line, with no bus cycle.
- R6: COMMIT (op 4) with `tstatus` 1 drops all XCOMMIT lines and turns all XABORT lines NORMAL in one cycle. The response follows on the next cycle with `resp_flag` 1, `tactive` 0 and `tstatus` 1. Commit starts no bus cycle.
- R7: ABORT (op 5) drops all XABORT lines and turns all XCOMMIT lines NORMAL in one cycle. It responds with `resp_flag` 0 and leaves `tactive` 0 and `tstatus` 1. Later loads see the pre-transaction value.
- R8: A BUSY reply to a fetch aborts the transaction's lines as in R7. It sets `tstatus` to 0, leaves `tactive` at 1, and responds with data 0 and `resp_flag` 0. The fetched line is not kept.
- R9: While `tactive` is 1 and `tstatus` is 0, a transactional access responds with data 0 and `resp_flag` 0 on the next cycle. It touches neither the lines nor the bus.
- R10: COMMIT while `tstatus` is 0 acts as ABORT and returns `resp_flag` 0, leaving `tstatus` 1 and `tactive` 0.
- R11: VALIDATE (op 3) returns `tstatus` in `resp_flag`. When that value is 0, VALIDATE also sets `tstatus` to 1 and `tactive` to 0. `tactive` 0 always implies `tstatus` 1.
- R12: When lines are short, victims are taken from NORMAL lines first, then XCOMMIT lines, never from XABORT lines or from the accessed address. A DIRTY victim is first written out with `bus_kind` 2, carrying its address and data. A clean victim is dropped silently.
- R13: If no victim remains, the transaction aborts as in R7. `tstatus` becomes 0, and the response carries `tx_trap` 1, data 0 and `resp_flag` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `req_ready` is 1 |
| req_op | input | 3 | 0 load, 1 load-exclusive, 2 store, 3 validate, 4 commit, 5 abort |
| req_addr | input | AW | Line address |
| req_wdata | input | DW | Store data |
| req_ready | output | 1 | Block is idle and can take a request |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_data | output | DW | Load data (0 for other operations) |
| resp_flag | output | 1 | Success or validate/commit result |
| tx_trap | output | 1 | Overflow trap, valid with the response |
| tactive | output | 1 | Transaction in progress |
| tstatus | output | 1 | Transaction has not been disturbed |
| bus_req | output | 1 | Bus cycle requested, held until granted |
| bus_kind | output | 2 | 0 shared read, 1 exclusive read, 2 write-back |
| bus_addr | output | AW | Bus cycle address |
| bus_wdata | output | DW | Write-back data |
| bus_gnt | input | 1 | Grant for the pending bus cycle |
| bus_rvalid | input | 1 | Read reply present |
| bus_busy | input | 1 | Reply is BUSY (else OK) |
| bus_rdata | input | DW | Read reply data |

## Verification
The assertions check several things on every cycle:
- `tactive` 0 implies `tstatus` 1.
- A held bus request keeps its address and kind until it is granted.
- A control operation is answered on the next cycle.
- Commit and abort leave no XCOMMIT or XABORT line behind.
- An orphaned access draws no bus cycle.
- A trap comes only with a failing response.
- There are never more XCOMMIT lines than XABORT lines.

Only the bench scenarios can show that the right data comes back after commit, abort and BUSY. The same holds for victim order (NORMAL before XCOMMIT, dirty before reuse) and for the exact point at which a full set of XABORT lines overflows.

// File: rtl/txcache.sv
module txcache #(
  parameter int LINES = 64,
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data,
  output logic          resp_flag,
  output logic          tx_trap,
  output logic          tactive,
  output logic          tstatus,
  output logic          bus_req,
  output logic [1:0]    bus_kind,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_gnt,
  input  logic          bus_rvalid,
  input  logic          bus_busy,
  input  logic [DW-1:0] bus_rdata
);
  localparam int IW = $clog2(LINES);

  localparam logic [2:0] OP_LT = 3'd0, OP_LTX = 3'd1, OP_ST = 3'd2;
  localparam logic [2:0] OP_VAL = 3'd3, OP_COMMIT = 3'd4;
  localparam logic [1:0] T_EMPTY = 2'd0, T_NORMAL = 2'd1, T_XCOMMIT = 2'd2, T_XABORT = 2'd3;
  localparam logic [1:0] C_INV = 2'd0, C_VALID = 2'd1, C_DIRTY = 2'd2, C_RES = 2'd3;
  localparam logic [1:0] K_TREAD = 2'd0, K_TRFO = 2'd1, K_WRITE = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_ROOM, S_WB, S_FETCH, S_WAIT} st_t;

  st_t st;
  logic [LINES-1:0][1:0] ltag, lst;
  logic [AW-1:0] laddr [LINES];
  logic [DW-1:0] ldata [LINES];

  logic [2:0]    op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [IW-1:0] vic_q;
  logic tactive_q, tstatus_q, resp_valid_q, resp_flag_q, trap_q;
  logic [DW-1:0] resp_data_q;

  logic xa_hit, nm_hit, e0_ok, e1_ok, vn_ok, vc_ok;
  logic [IW-1:0] xa_idx, nm_idx, e0, e1, vn, vc;
  logic [LINES-1:0][1:0] cm_tag, cm_st, ab_tag, ab_st;

  always_comb begin
    xa_hit = 1'b0; nm_hit = 1'b0; e0_ok = 1'b0; e1_ok = 1'b0; vn_ok = 1'b0; vc_ok = 1'b0;
    xa_idx = '0; nm_idx = '0; e0 = '0; e1 = '0; vn = '0; vc = '0;
    for (int i = 0; i < LINES; i++) begin
      if (ltag[i] == T_EMPTY) begin
        if (!e0_ok) begin e0_ok = 1'b1; e0 = IW'(i); end
        else if (!e1_ok) begin e1_ok = 1'b1; e1 = IW'(i); end
      end else if (laddr[i] == addr_q) begin
        if (ltag[i] == T_XABORT) begin xa_hit = 1'b1; xa_idx = IW'(i); end
        if (ltag[i] == T_NORMAL) begin nm_hit = 1'b1; nm_idx = IW'(i); end
      end else begin
        if (ltag[i] == T_NORMAL && !vn_ok) begin vn_ok = 1'b1; vn = IW'(i); end
        if (ltag[i] == T_XCOMMIT && !vc_ok) begin vc_ok = 1'b1; vc = IW'(i); end
      end
    end
  end

  always_comb begin
    cm_tag = ltag; cm_st = lst; ab_tag = ltag; ab_st = lst;
    for (int i = 0; i < LINES; i++) begin
      if (ltag[i] == T_XCOMMIT) begin
        cm_tag[i] = T_EMPTY; cm_st[i] = C_INV; ab_tag[i] = T_NORMAL;
      end else if (ltag[i] == T_XABORT) begin
        ab_tag[i] = T_EMPTY; ab_st[i] = C_INV; cm_tag[i] = T_NORMAL;
      end
    end
  end

  wire room_ok = nm_hit ? e0_ok : e1_ok;
  wire victim_ok = vn_ok | vc_ok;
  wire [IW-1:0] victim = vn_ok ? vn : vc;
  wire is_st = (op_q == OP_ST);
  wire [1:0] fill_st = (op_q == OP_LT) ? C_VALID : C_RES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ltag <= '0;
      lst <= '0;
      for (int i = 0; i < LINES; i++) begin
        laddr[i] <= '0;
        ldata[i] <= '0;
      end
      op_q <= '0; addr_q <= '0; wdata_q <= '0; vic_q <= '0;
      tactive_q <= 1'b0; tstatus_q <= 1'b1;
      resp_valid_q <= 1'b0; resp_flag_q <= 1'b0; resp_data_q <= '0; trap_q <= 1'b0;
    end else begin
      resp_valid_q <= 1'b0;
      trap_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q <= req_op; addr_q <= req_addr; wdata_q <= req_wdata;
          if (req_op <= OP_ST) begin
            if (tactive_q && !tstatus_q) begin
              resp_valid_q <= 1'b1; resp_data_q <= '0; resp_flag_q <= 1'b0;
            end else begin
              tactive_q <= 1'b1;
              st <= S_ROOM;
            end
          end else begin
            resp_valid_q <= 1'b1;
            resp_data_q <= '0;
            if (req_op == OP_VAL) begin
              resp_flag_q <= tstatus_q;
              if (!tstatus_q) begin tstatus_q <= 1'b1; tactive_q <= 1'b0; end
            end else if (req_op == OP_COMMIT && tstatus_q) begin
              resp_flag_q <= 1'b1; tactive_q <= 1'b0;
              ltag <= cm_tag; lst <= cm_st;
            end else begin
              resp_flag_q <= 1'b0; tactive_q <= 1'b0; tstatus_q <= 1'b1;
              ltag <= ab_tag; lst <= ab_st;
            end
          end
        end
        S_ROOM: begin
          if (xa_hit) begin
            resp_valid_q <= 1'b1; resp_flag_q <= 1'b1;
            if (is_st) begin
              ldata[xa_idx] <= wdata_q; lst[xa_idx] <= C_DIRTY; resp_data_q <= '0;
            end else begin
              resp_data_q <= ldata[xa_idx];
            end
            st <= S_IDLE;
          end else if (room_ok) begin
            if (nm_hit) begin
              ltag[nm_idx] <= T_XCOMMIT;
              ltag[e0] <= T_XABORT;
              laddr[e0] <= addr_q;
              ldata[e0] <= is_st ? wdata_q : ldata[nm_idx];
              lst[e0] <= is_st ? C_DIRTY : lst[nm_idx];
              resp_data_q <= is_st ? '0 : ldata[nm_idx];
              resp_valid_q <= 1'b1; resp_flag_q <= 1'b1;
              st <= S_IDLE;
            end else begin
              st <= S_FETCH;
            end
          end else if (victim_ok) begin
            if (lst[victim] == C_DIRTY) begin
              vic_q <= victim; st <= S_WB;
            end else begin
              ltag[victim] <= T_EMPTY; lst[victim] <= C_INV;
            end
          end else begin
            ltag <= ab_tag; lst <= ab_st;
            tstatus_q <= 1'b0; trap_q <= 1'b1;
            resp_valid_q <= 1'b1; resp_data_q <= '0; resp_flag_q <= 1'b0;
            st <= S_IDLE;
          end
        end
        S_WB: if (bus_gnt) begin
          ltag[vic_q] <= T_EMPTY; lst[vic_q] <= C_INV;
          st <= S_ROOM;
        end
        S_FETCH: if (bus_gnt) st <= S_WAIT;
        S_WAIT: if (bus_rvalid) begin
          resp_valid_q <= 1'b1;
          st <= S_IDLE;
          if (bus_busy) begin
            ltag <= ab_tag; lst <= ab_st;
            tstatus_q <= 1'b0; resp_data_q <= '0; resp_flag_q <= 1'b0;
          end else begin
            ltag[e0] <= T_XCOMMIT; laddr[e0] <= addr_q; ldata[e0] <= bus_rdata; lst[e0] <= fill_st;
            ltag[e1] <= T_XABORT; laddr[e1] <= addr_q;
            ldata[e1] <= is_st ? wdata_q : bus_rdata;
            lst[e1] <= is_st ? C_DIRTY : fill_st;
            resp_data_q <= is_st ? '0 : bus_rdata;
            resp_flag_q <= 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign resp_valid = resp_valid_q;
  assign resp_data  = resp_data_q;
  assign resp_flag  = resp_flag_q;
  assign tx_trap    = trap_q;
  assign tactive    = tactive_q;
  assign tstatus    = tstatus_q;
  assign bus_req    = (st == S_WB) || (st == S_FETCH);
  assign bus_kind   = (st == S_WB) ? K_WRITE : ((op_q == OP_LT) ? K_TREAD : K_TRFO);
  assign bus_addr   = (st == S_WB) ? laddr[vic_q] : addr_q;
  assign bus_wdata  = (st == S_WB) ? ldata[vic_q] : '0;
endmodule

// File: rtl/txcache_chk.sv
module txcache_chk #(
  parameter int LINES = 64,
  parameter int AW = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_valid,
  input logic                  req_ready,
  input logic [2:0]            req_op,
  input logic                  resp_valid,
  input logic                  resp_flag,
  input logic                  tx_trap,
  input logic                  tactive,
  input logic                  tstatus,
  input logic                  bus_req,
  input logic                  bus_gnt,
  input logic [1:0]            bus_kind,
  input logic [AW-1:0]         bus_addr,
  input logic [LINES-1:0][1:0] ltag
);
  int n_xc, n_xa;
  always_comb begin
    n_xc = 0; n_xa = 0;
    for (int i = 0; i < LINES; i++) begin
      if (ltag[i] == 2'd2) n_xc++;
      if (ltag[i] == 2'd3) n_xa++;
    end
  end

  wire take = req_valid && req_ready;

  p_idle_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tactive |-> tstatus);

  p_ctrl_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_op >= 3'd3 |=> resp_valid);

  p_commit_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_op == 3'd4 && tstatus |=> n_xc == 0 && n_xa == 0 && resp_flag && !tactive);

  p_abort_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_op == 3'd5 |=> n_xc == 0 && n_xa == 0 && !tactive && tstatus && !resp_flag);

  p_commit_false_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_op == 3'd4 && !tstatus |=> !resp_flag && tstatus && !tactive);

  p_orphan_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_op <= 3'd2 && tactive && !tstatus |=> resp_valid && !bus_req && !resp_flag);

  p_bus_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_kind));

  p_trap_fail_r13: assert property (@(posedge clk) disable iff (!rst_n)
    tx_trap |-> resp_valid && !resp_flag && !tstatus);

  p_copy_pairs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    n_xc <= n_xa);
endmodule

bind txcache txcache_chk #(.LINES(LINES), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
  .resp_valid(resp_valid), .resp_flag(resp_flag), .tx_trap(tx_trap), .tactive(tactive),
  .tstatus(tstatus), .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_kind(bus_kind),
  .bus_addr(bus_addr), .ltag(ltag)
);

// File: tb/txcache_test.sv
`timescale 1ns/1ps
module txcache_test;
  localparam int AW = 32, DW = 64;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, resp_valid, resp_flag, tx_trap, tactive, tstatus, bus_req;
  logic [DW-1:0] resp_data, bus_wdata;
  logic [1:0] bus_kind;
  logic [AW-1:0] bus_addr;
  logic bus_gnt = 1'b0, bus_rvalid = 1'b0, bus_busy = 1'b0;
  logic [DW-1:0] bus_rdata = '0;

  always #2 clk = ~clk;

  txcache #(.LINES(8), .AW(AW), .DW(DW)) uut (.*);

  int checks = 0, errors = 0;
  logic [DW-1:0] g_data;
  logic g_flag, g_trap, wr_first;
  int n_rd, n_wr;
  logic [1:0] rd_kind;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [DW-1:0] wr_data;

  function automatic logic [DW-1:0] mem(input logic [AW-1:0] a);
    return {32'hC0DE0000, a};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 1'b0; bus_gnt = 1'b0; bus_rvalid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_op(input logic [2:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd, input bit busy);
    bit pend = 1'b0, done = 1'b0;
    n_rd = 0; n_wr = 0; wr_first = 1'b0; g_trap = 1'b0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int c = 0; c < 200 && !done; c++) begin
      bus_gnt = 1'b0; bus_rvalid = 1'b0;
      if (resp_valid) begin
        g_data = resp_data; g_flag = resp_flag; g_trap = tx_trap; done = 1'b1;
      end else begin
        if (pend) begin
          bus_rvalid = 1'b1; bus_busy = busy; bus_rdata = mem(rd_addr); pend = 1'b0;
        end else if (bus_req) begin
          bus_gnt = 1'b1;
          if (bus_kind == 2'd2) begin
            if (n_wr == 0 && n_rd == 0) wr_first = 1'b1;
            n_wr++; wr_addr = bus_addr; wr_data = bus_wdata;
          end else begin
            n_rd++; rd_kind = bus_kind; rd_addr = bus_addr; pend = 1'b1;
          end
        end
        @(negedge clk);
      end
    end
    bus_gnt = 1'b0; bus_rvalid = 1'b0;
    if (!done) chk(1'b0, "response timeout", 0, 1);
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] a;
    logic [63:0] wd;
    logic [63:0] ed;
    logic        ef;
    logic [1:0]  eb;
    logic [3:0]  rq;
  } vec_t;

  // eb: 3 = no bus cycle, 0 shared read, 1 exclusive read
  localparam vec_t VEC [13] = '{
    '{3'd0, 16'h10, 64'h0,    64'hC0DE000000000010, 1'b1, 2'd0, 4'd3},  // R3 load miss
    '{3'd0, 16'h10, 64'h0,    64'hC0DE000000000010, 1'b1, 2'd3, 4'd4},  // R4 XABORT hit
    '{3'd2, 16'h10, 64'h1111, 64'h0,                1'b1, 2'd3, 4'd4},  // R4 store on hit
    '{3'd0, 16'h10, 64'h0,    64'h1111,             1'b1, 2'd3, 4'd4},  // R4 sees store
    '{3'd2, 16'h20, 64'h2222, 64'h0,                1'b1, 2'd1, 4'd3},  // R3 store miss
    '{3'd1, 16'h30, 64'h0,    64'hC0DE000000000030, 1'b1, 2'd1, 4'd3},  // R3 ltx miss
    '{3'd4, 16'h0,  64'h0,    64'h0,                1'b1, 2'd3, 4'd6},  // R6 commit, no write
    '{3'd0, 16'h10, 64'h0,    64'h1111,             1'b1, 2'd3, 4'd5},  // R5 NORMAL hit
    '{3'd2, 16'h10, 64'h3333, 64'h0,                1'b1, 2'd3, 4'd4},
    '{3'd5, 16'h0,  64'h0,    64'h0,                1'b0, 2'd3, 4'd7},  // R7 abort
    '{3'd0, 16'h10, 64'h0,    64'h1111,             1'b1, 2'd3, 4'd7},  // R7 old value back
    '{3'd3, 16'h0,  64'h0,    64'h0,                1'b1, 2'd3, 4'd11}, // R11 validate true
    '{3'd4, 16'h0,  64'h0,    64'h0,                1'b1, 2'd3, 4'd6}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(!tactive && tstatus, "R1 status", {tactive, tstatus}, 2'b01);
    chk(!bus_req && !resp_valid && !tx_trap && req_ready, "R1 outputs",
        {bus_req, resp_valid, tx_trap, req_ready}, 4'b0001);

    foreach (VEC[i]) begin
      string rq;
      rq = $sformatf("R%0d row %0d", VEC[i].rq, i);
      do_op(VEC[i].op, AW'(VEC[i].a), VEC[i].wd, 1'b0);
      chk(g_flag == VEC[i].ef, {rq, " flag"}, g_flag, VEC[i].ef);
      if (VEC[i].op <= 3'd1) chk(g_data == VEC[i].ed, {rq, " data"}, g_data, VEC[i].ed);
      if (VEC[i].eb == 2'd3)
        chk(n_rd == 0 && n_wr == 0, {rq, " no bus"}, n_rd + n_wr, 0);
      else
        chk(n_rd == 1 && rd_kind == VEC[i].eb && rd_addr == AW'(VEC[i].a), {rq, " bus read"}, rd_kind, VEC[i].eb);
      if (i == 0) chk(tactive, "R2 tactive set", tactive, 1);
      if (i == 6) chk(!tactive && tstatus, "R6 status after commit", {tactive, tstatus}, 2'b01);
    end

    // R12 victim order and write-back
    do_reset();
    do_op(3'd2, 32'h100, 64'hAAAA, 1'b0);
    do_op(3'd4, 0, 0, 1'b0);
    do_op(3'd0, 32'h200, 0, 1'b0);
    do_op(3'd0, 32'h300, 0, 1'b0);
    do_op(3'd0, 32'h400, 0, 1'b0);
    do_op(3'd0, 32'h500, 0, 1'b0);
    chk(n_wr == 1 && wr_first, "R12 dirty NORMAL written first", n_wr, 1);
    chk(wr_addr == 32'h100 && wr_data == 64'hAAAA, "R12 write-back content", wr_data, 64'hAAAA);
    chk(n_rd == 1 && g_data == mem(32'h500), "R12 fill after eviction", g_data, mem(32'h500));
    do_op(3'd0, 32'h600, 0, 1'b0);
    chk(n_wr == 0 && n_rd == 1, "R12 clean XCOMMIT dropped", n_wr, 0);
    do_op(3'd0, 32'h200, 0, 1'b0);
    chk(n_rd == 0 && g_data == mem(32'h200), "R4 XABORT copy kept", g_data, mem(32'h200));
    do_op(3'd0, 32'h700, 0, 1'b0);
    do_op(3'd0, 32'h800, 0, 1'b0);
    chk(!g_trap && g_flag, "R12 still room", g_flag, 1);
    // R13 overflow
    do_op(3'd0, 32'h900, 0, 1'b0);
    chk(g_trap && !g_flag && n_rd == 0, "R13 trap", {g_trap, g_flag}, 2'b10);
    chk(!tstatus && tactive, "R13 status", {tactive, tstatus}, 2'b10);
    // R9 orphan
    do_op(3'd0, 32'h200, 0, 1'b0);
    chk(g_data == 0 && !g_flag && n_rd == 0 && n_wr == 0, "R9 orphan access", g_data, 0);
    // R10 commit as abort
    do_op(3'd4, 0, 0, 1'b0);
    chk(!g_flag && tstatus && !tactive, "R10 commit fails", {g_flag, tactive, tstatus}, 3'b001);
    do_op(3'd0, 32'h200, 0, 1'b0);
    chk(n_rd == 1, "R13 tentative copies gone", n_rd, 1);

    // R8 BUSY reply
    do_reset();
    do_op(3'd0, 32'h10, 0, 1'b1);
    chk(g_data == 0 && !g_flag, "R8 busy response", g_data, 0);
    chk(!tstatus && tactive, "R8 status", {tactive, tstatus}, 2'b10);
    // R11 validate resets
    do_op(3'd3, 0, 0, 1'b0);
    chk(!g_flag && tstatus && !tactive, "R11 validate false", {g_flag, tactive, tstatus}, 3'b001);
    do_op(3'd3, 0, 0, 1'b0);
    chk(g_flag, "R11 validate true", g_flag, 1);
    do_op(3'd0, 32'h10, 0, 1'b0);
    chk(n_rd == 1 && g_data == mem(32'h10), "R8 line not kept", n_rd, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule